// File: doc/BRIEF.md
# Two-Port Semaphore Flag Unit

This block holds a bank of hardware lock flags that two independent masters, a left port and a right port, share for resource locking. It needs no shared memory. A port reaches the flags when its semaphore select is low and its memory chip enable is inactive. The low address bits pick one flag. On a write, only data bit 0 counts: 0 asks for the flag and 1 gives it back. On a read, the port's view of the flag is copied onto every data line.

A port sees a flag as taken (0) only while it holds that flag itself. A request made while the other port holds the flag is kept as pending. It is granted without further action when the holder releases. If both ports ask for a free flag in the same cycle, the left port wins and the right request stays pending. If a port asserts its semaphore select while its memory chip enable is active, the access is illegal. It changes nothing and raises an error pulse on that port.

The block is synchronous to `clk_i`. A write takes effect at the clock edge that samples it. A read is sampled at an edge and its data appear on that edge's registered output.

Top module: `sem_unit`

## Requirements
- R1: After reset, every flag is free. Both ports read 9'h1FF, and both error outputs are 0.
- R2: Address bits [2:0] select one of 8 flags. An access to one flag does not change any other flag.
- R3: A semaphore write takes its value from data bit 0 only. Bits [8:1] are ignored.
- R4: A read returns the port's view of the flag on all 9 data lines: 9'h000 if the port holds the flag, otherwise 9'h1FF. The data are registered at the sampling edge.
- R5: A semaphore read needs sem_n=0, cs_n=1, we_n=1 and oe_n=0. When the port makes no read, its read data hold their last value.
- R6: Writing 0 to a flag the other port does not hold grants it at once. The holder then reads 0 and the other port reads 1, and the two ports never hold the same flag together.
- R7: Writing 0 while the other port holds the flag leaves the request pending. When the holder writes 1, the flag passes to the pending port at that same edge.
- R8: If both ports write 0 to the same free flag in one cycle, the left port is granted and the right request stays pending.
- R9: Writing 1 from a port that neither holds the flag nor has a request pending on it has no effect.
- R10: sem_n=0 together with cs_n=0 is illegal. It changes no flag, and the port's error output is 1 for the cycle after that edge. No other access raises the error output.
- R11: Writing 1 from a port whose request is pending cancels that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_sem_n_i | input | 1 | Left semaphore select, active low |
| l_cs_n_i | input | 1 | Left memory chip enable, active low |
| l_we_n_i | input | 1 | Left read/write: 1 read, 0 write |
| l_oe_n_i | input | 1 | Left output enable, active low |
| l_addr_i | input | 3 | Left flag index |
| l_wdata_i | input | 9 | Left write data; only bit 0 is used |
| l_rdata_o | output | 9 | Left read data, registered |
| l_err_o | output | 1 | Left illegal-access pulse |
| r_sem_n_i | input | 1 | Right semaphore select, active low |
| r_cs_n_i | input | 1 | Right memory chip enable, active low |
| r_we_n_i | input | 1 | Right read/write: 1 read, 0 write |
| r_oe_n_i | input | 1 | Right output enable, active low |
| r_addr_i | input | 3 | Right flag index |
| r_wdata_i | input | 9 | Right write data; only bit 0 is used |
| r_rdata_o | output | 9 | Right read data, registered |
| r_err_o | output | 1 | Right illegal-access pulse |

## Verification
A write changes the flag state at the edge that samples it. A read registers its data at its own sampling edge, so every read result is checked at the falling edge right after the read's rising edge. An effect of a write is observed through a read issued in the next cycle. An error pulse is due in the cycle after the illegal edge, and the bench samples it at the following falling edge, before the next edge clears it. Inputs change only on falling edges, so each access is sampled at exactly one rising edge.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef struct packed {
    logic sem_n;
    logic cs_n;
    logic we_n;
    logic oe_n;
  } port_ctl_t;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
  import sem_pkg::*;
#(
  parameter int N_FLAGS = 8,
  localparam int AW = $clog2(N_FLAGS)
) (
  input  port_ctl_t          ctl_i,
  input  logic [AW-1:0]      addr_i,
  input  logic               bit0_i,
  output logic [N_FLAGS-1:0] req_o,
  output logic [N_FLAGS-1:0] rel_o,
  output logic               rd_o,
  output logic               illegal_o
);
  logic sel, wr;
  logic [N_FLAGS-1:0] hit;

  assign sel       = ~ctl_i.sem_n & ctl_i.cs_n;
  assign illegal_o = ~ctl_i.sem_n & ~ctl_i.cs_n;
  assign wr        = sel & ~ctl_i.we_n;
  assign rd_o      = sel & ctl_i.we_n & ~ctl_i.oe_n;

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_hit
    assign hit[i]   = (addr_i == AW'(i));
    assign req_o[i] = wr & hit[i] & ~bit0_i;
    assign rel_o[i] = wr & hit[i] & bit0_i;
  end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_l_i,
  input  logic rel_l_i,
  input  logic req_r_i,
  input  logic rel_r_i,
  output logic own_l_o,
  output logic own_r_o
);
  logic own_l_q, own_r_q, pend_l_q, pend_r_q;
  logic want_l, want_r, own_l_d, own_r_d;

  // a port still wants the flag unless it releases in this cycle
  assign want_l = own_l_q ? ~rel_l_i : (req_l_i | (pend_l_q & ~rel_l_i));
  assign want_r = own_r_q ? ~rel_r_i : (req_r_i | (pend_r_q & ~rel_r_i));

  always_comb begin
    own_l_d = 1'b0;
    own_r_d = 1'b0;
    if (own_l_q && want_l)      own_l_d = 1'b1;
    else if (own_r_q && want_r) own_r_d = 1'b1;
    else if (want_l)            own_l_d = 1'b1;  // left wins a tie
    else if (want_r)            own_r_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_l_q  <= 1'b0;
      own_r_q  <= 1'b0;
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else begin
      own_l_q  <= own_l_d;
      own_r_q  <= own_r_d;
      pend_l_q <= want_l & ~own_l_d;
      pend_r_q <= want_r & ~own_r_d;
    end
  end

  assign own_l_o = own_l_q;
  assign own_r_o = own_r_q;
endmodule

// File: rtl/sem_unit.sv
module sem_unit
  import sem_pkg::*;
#(
  parameter int N_FLAGS = 8,
  parameter int DW      = 9,
  localparam int AW     = $clog2(N_FLAGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          l_sem_n_i,
  input  logic          l_cs_n_i,
  input  logic          l_we_n_i,
  input  logic          l_oe_n_i,
  input  logic [AW-1:0] l_addr_i,
  input  logic [DW-1:0] l_wdata_i,
  output logic [DW-1:0] l_rdata_o,
  output logic          l_err_o,
  input  logic          r_sem_n_i,
  input  logic          r_cs_n_i,
  input  logic          r_we_n_i,
  input  logic          r_oe_n_i,
  input  logic [AW-1:0] r_addr_i,
  input  logic [DW-1:0] r_wdata_i,
  output logic [DW-1:0] r_rdata_o,
  output logic          r_err_o
);
  port_ctl_t l_ctl, r_ctl;
  logic [N_FLAGS-1:0] l_req, l_rel, r_req, r_rel;
  logic [N_FLAGS-1:0] own_l_w, own_r_w;
  logic l_rd, r_rd, l_ill, r_ill;
  logic [DW-1:0] l_rdata_q, r_rdata_q;
  logic l_err_q, r_err_q;
  logic unused_hi;

  assign unused_hi = ^{l_wdata_i[DW-1:1], r_wdata_i[DW-1:1]};
  assign l_ctl = '{sem_n: l_sem_n_i, cs_n: l_cs_n_i, we_n: l_we_n_i, oe_n: l_oe_n_i};
  assign r_ctl = '{sem_n: r_sem_n_i, cs_n: r_cs_n_i, we_n: r_we_n_i, oe_n: r_oe_n_i};

  sem_port_decode #(.N_FLAGS(N_FLAGS)) u_dec_l (
    .ctl_i(l_ctl), .addr_i(l_addr_i), .bit0_i(l_wdata_i[0]),
    .req_o(l_req), .rel_o(l_rel), .rd_o(l_rd), .illegal_o(l_ill)
  );
  sem_port_decode #(.N_FLAGS(N_FLAGS)) u_dec_r (
    .ctl_i(r_ctl), .addr_i(r_addr_i), .bit0_i(r_wdata_i[0]),
    .req_o(r_req), .rel_o(r_rel), .rd_o(r_rd), .illegal_o(r_ill)
  );

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    sem_flag_cell u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .req_l_i(l_req[i]), .rel_l_i(l_rel[i]),
      .req_r_i(r_req[i]), .rel_r_i(r_rel[i]),
      .own_l_o(own_l_w[i]), .own_r_o(own_r_w[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_rdata_q <= '1;
      r_rdata_q <= '1;
      l_err_q   <= 1'b0;
      r_err_q   <= 1'b0;
    end else begin
      if (l_rd) l_rdata_q <= {DW{~own_l_w[l_addr_i]}};
      if (r_rd) r_rdata_q <= {DW{~own_r_w[r_addr_i]}};
      l_err_q <= l_ill;
      r_err_q <= r_ill;
    end
  end

  assign l_rdata_o = l_rdata_q;
  assign r_rdata_o = r_rdata_q;
  assign l_err_o   = l_err_q;
  assign r_err_o   = r_err_q;
endmodule

// File: rtl/sem_unit_chk.sv
module sem_unit_chk #(
  parameter int N_FLAGS = 8,
  parameter int DW      = 9,
  localparam int AW     = $clog2(N_FLAGS)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               l_sem_n_i,
  input logic               l_cs_n_i,
  input logic               l_we_n_i,
  input logic [AW-1:0]      l_addr_i,
  input logic [DW-1:0]      l_wdata_i,
  input logic [DW-1:0]      l_rdata_o,
  input logic               l_err_o,
  input logic               r_sem_n_i,
  input logic               r_cs_n_i,
  input logic               r_we_n_i,
  input logic [AW-1:0]      r_addr_i,
  input logic [DW-1:0]      r_wdata_i,
  input logic [DW-1:0]      r_rdata_o,
  input logic               r_err_o,
  input logic [N_FLAGS-1:0] own_l_w,
  input logic [N_FLAGS-1:0] own_r_w
);
  p_one_holder_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l_w & own_r_w) == '0);

  p_replicate_l_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_rdata_o == '0) || (l_rdata_o == '1));

  p_replicate_r_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_rdata_o == '0) || (r_rdata_o == '1));

  p_err_l_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_sem_n_i && !l_cs_n_i) |=> l_err_o);

  p_err_r_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_sem_n_i && !r_cs_n_i) |=> r_err_o);

  p_no_action_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_sem_n_i && !l_cs_n_i && r_sem_n_i) |=> ($stable(own_l_w) && $stable(own_r_w)));

  p_left_grant_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_sem_n_i && l_cs_n_i && !l_we_n_i && !l_wdata_i[0]
      && !own_r_w[l_addr_i]) |=> own_l_w[$past(l_addr_i)]);

  p_right_blocked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_sem_n_i && r_cs_n_i && !r_we_n_i && !r_wdata_i[0] && own_l_w[r_addr_i]
      && !(!l_sem_n_i && l_cs_n_i && !l_we_n_i && l_wdata_i[0]))
      |=> !own_r_w[$past(r_addr_i)]);
endmodule

bind sem_unit sem_unit_chk #(.N_FLAGS(N_FLAGS), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .l_sem_n_i(l_sem_n_i), .l_cs_n_i(l_cs_n_i), .l_we_n_i(l_we_n_i),
  .l_addr_i(l_addr_i), .l_wdata_i(l_wdata_i), .l_rdata_o(l_rdata_o), .l_err_o(l_err_o),
  .r_sem_n_i(r_sem_n_i), .r_cs_n_i(r_cs_n_i), .r_we_n_i(r_we_n_i),
  .r_addr_i(r_addr_i), .r_wdata_i(r_wdata_i), .r_rdata_o(r_rdata_o), .r_err_o(r_err_o),
  .own_l_w(own_l_w), .own_r_w(own_r_w)
);

// File: tb/sem_unit_bench.sv
`timescale 1ns/1ps
module sem_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic l_sem_n, l_cs_n, l_we_n, l_oe_n, r_sem_n, r_cs_n, r_we_n, r_oe_n;
  logic [2:0] l_addr, r_addr;
  logic [8:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_err, r_err;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  sem_unit u_sem_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .l_sem_n_i(l_sem_n), .l_cs_n_i(l_cs_n), .l_we_n_i(l_we_n), .l_oe_n_i(l_oe_n),
    .l_addr_i(l_addr), .l_wdata_i(l_wdata), .l_rdata_o(l_rdata), .l_err_o(l_err),
    .r_sem_n_i(r_sem_n), .r_cs_n_i(r_cs_n), .r_we_n_i(r_we_n), .r_oe_n_i(r_oe_n),
    .r_addr_i(r_addr), .r_wdata_i(r_wdata), .r_rdata_o(r_rdata), .r_err_o(r_err)
  );

  task automatic chk(input logic [8:0] act, input logic [8:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_l(input logic s, c, w, o, input logic [2:0] a, input logic [8:0] d);
    l_sem_n = s; l_cs_n = c; l_we_n = w; l_oe_n = o; l_addr = a; l_wdata = d;
  endtask
  task automatic set_r(input logic s, c, w, o, input logic [2:0] a, input logic [8:0] d);
    r_sem_n = s; r_cs_n = c; r_we_n = w; r_oe_n = o; r_addr = a; r_wdata = d;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    set_l(1, 1, 1, 1, 0, 0);
    set_r(1, 1, 1, 1, 0, 0);
  endtask

  task automatic lwr(input logic [2:0] a, input logic [8:0] d); set_l(0, 1, 0, 1, a, d); endtask
  task automatic rwr(input logic [2:0] a, input logic [8:0] d); set_r(0, 1, 0, 1, a, d); endtask

  // read flag a on both ports; exp_l/exp_r: port holds the flag
  task automatic rd_both(input logic [2:0] a, input logic hl, input logic hr, input string tag);
    set_l(0, 1, 1, 0, a, 0);
    set_r(0, 1, 1, 0, a, 0);
    tick();
    chk(l_rdata, hl ? 9'h000 : 9'h1FF, {tag, " left"});
    chk(r_rdata, hr ? 9'h000 : 9'h1FF, {tag, " right"});
  endtask

  initial begin
    set_l(1, 1, 1, 1, 0, 0);
    set_r(1, 1, 1, 1, 0, 0);
    #45 rst_n = 1'b1;
    @(negedge clk);
    chk(l_rdata, 9'h1FF, "R1 reset left rdata");
    chk(r_rdata, 9'h1FF, "R1 reset right rdata");
    chk({8'h0, l_err | r_err}, 9'h0, "R1 reset err");
    for (int f = 0; f < 8; f++) rd_both(3'(f), 0, 0, "R1 free after reset");

    for (int f = 0; f < 8; f++) begin
      logic [2:0] a = 3'(f), o = 3'(f + 1);
      lwr(a, 9'h1FE); tick();                       // upper bits set, bit0=0
      rd_both(a, 1, 0, "R3 R4 R6 left grant");
      rd_both(o, 0, 0, "R2 neighbour untouched");
      rwr(a, 9'h000); tick();
      rd_both(a, 1, 0, "R7 right pending");
      lwr(a, 9'h001); tick();
      rd_both(a, 0, 1, "R7 handed to right");
      lwr(a, 9'h001); tick();
      rd_both(a, 0, 1, "R9 stray release");
      rwr(a, 9'h0FF); tick();
      rd_both(a, 0, 0, "R6 released");
      lwr(a, 9'h000); rwr(a, 9'h000); tick();
      rd_both(a, 1, 0, "R8 tie to left");
      lwr(a, 9'h001); tick();
      rd_both(a, 0, 1, "R8 right pending granted");
      rwr(a, 9'h001); tick();
      lwr(a, 9'h000); rwr(a, 9'h000); tick();
      rwr(a, 9'h001); tick();                       // cancel pending
      lwr(a, 9'h001); tick();
      rd_both(a, 0, 0, "R11 cancelled request");
      rwr(a, 9'h000); tick();
      rd_both(a, 0, 1, "R6 right grant");
      rwr(a, 9'h001); tick();
    end

    // R5: no read keeps the last data
    lwr(0, 0); tick();
    rd_both(0, 1, 0, "R5 setup");
    set_l(0, 1, 1, 1, 1, 0); tick();                // oe_n high
    chk(l_rdata, 9'h000, "R5 oe_n high holds");
    set_l(1, 1, 1, 0, 1, 0); tick();                // sem_n high
    chk(l_rdata, 9'h000, "R5 sem_n high holds");
    lwr(0, 1); tick();

    // R10 illegal access
    for (int f = 0; f < 8; f++) begin
      set_l(0, 0, 0, 1, 3'(f), 0); tick();
      chk({8'h0, l_err}, 9'h001, "R10 left err pulse");
      chk({8'h0, r_err}, 9'h000, "R10 right quiet");
      set_r(0, 0, 0, 1, 3'(f), 0); tick();
      chk({8'h0, r_err}, 9'h001, "R10 right err pulse");
      rd_both(3'(f), 0, 0, "R10 no action");
      chk({8'h0, l_err | r_err}, 9'h000, "R10 err clears");
    end
    set_l(1, 0, 0, 1, 0, 0); tick();                // memory access only
    chk({8'h0, l_err}, 9'h000, "R10 memory access no err");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule